// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block is a register-file target on a two-wire serial bus. The bus has a clock line and an open-drain data line. The block holds a bank of 8-bit control registers and drives their contents onto a flat parallel output, where the clock-control logic reads them. A bus master can reach the bank in two ways. An indexed single-byte access reads or writes one register. A sequential block access always starts at register zero.

Both bus lines are oversampled by the system clock through two-flop synchronisers. START is detected as a falling edge on data while the bus clock is high, and STOP as a rising edge on data while the bus clock is high. The block pulls the data line low only through `sda_oe`, and it changes that drive only while the bus clock is low.

Some bits are read-only and keep their value whatever is written. One register reports a fixed identification value. A few bits of register 0 mirror a strap input. One register holds a byte count, and that count sets how many data bytes a block read returns.

Top module: `smb_regfile_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal DEV_ADDR (69h, so D2h to write and D3h to read). Any other address gets no acknowledge on that byte or on any later byte up to the next START, and leaves every register unchanged.
- R2: A command byte with bit 7 = 1 selects a single-byte access at the offset in bits 6:0. A command byte with bit 7 = 0 selects a block access that starts at offset 0.
- R3: In a byte write (address, command, data), every byte is acknowledged, and the data byte lands in the register at the commanded offset.
- R4: In a block write, the byte after the command is a count byte. It is acknowledged and not stored. The data bytes that follow land at offsets 0, 1, 2 and onward. If the master stops partway, only the bytes it completed are written.
- R5: In a byte read (address, command, repeated START, read address), the block returns the register at the commanded offset, most significant bit first. After the master's NACK it releases the data line.
- R6: In a block read, the block first returns the value of the count register (offset CNT_IDX = 8). It then returns that many registers, starting at offset 0. Every byte after those returns FFh.
- R7: The count register resets to 15 (0Fh), and it can be written like any read/write register. A new value changes the length of later block reads.
- R8: Bits set in RO_MASK ignore writes. With the default masks, offset 7 is fully read-only and offset 0 bits 2:0 are read-only. Offset 0 bits 2:0 always read the current value of `strap_fs`.
- R9: During and after reset, each register holds its DEFAULTS byte (byte i at bits 8i+7:8i), except the strap-mirrored bits.
- R10: Offsets at or above NREGS read as FFh. Writes to them are acknowledged and change nothing.
- R11: The block starts pulling the data line low only while the bus clock is low, and stored register bits change only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Data line as seen on the wire |
| sda_oe | output | 1 | When 1, the data line is pulled low |
| strap_fs | input | FS_W (3) | Strap bits mirrored into offset 0 |
| regs_out | output | 8*NREGS (128) | All registers as read back; register i sits at bits 8i+7:8i |

## Verification
The corner cases targeted are these:
- **Block-read length.** The bench shortens the count register and reads past its end. A design that ignored the count, or that counted the count byte itself, would return register data where FFh is due.
- **Partial block write.** A block write is stopped after two data bytes. A design that wrote on the count byte, or that buffered data until STOP, would leave the wrong offsets changed.
- **Foreign address.** A transaction to another address must neither be acknowledged nor write anything.
- **Read-only bits.** Writes to the identification byte and to the strap bits must leave them intact, even while the strap moves.
- **Out-of-range offset.** A mis-sized range check would alias an offset above the bank onto a real register.

// File: rtl/smb_regfile_slave.sv
module smb_regfile_slave #(
  parameter int NREGS = 16,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int CNT_IDX = 8,
  parameter int FS_IDX = 0,
  parameter int FS_W = 3,
  parameter logic [8*NREGS-1:0] DEFAULTS = 128'h00A8A0B4B700E10F2A551000C0BEF800,
  parameter logic [8*NREGS-1:0] RO_MASK  = 128'h0000000000000000FF00000000000007
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output logic                 sda_oe,
  input  logic [FS_W-1:0]      strap_fs,
  output logic [8*NREGS-1:0]   regs_out
);
  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WR, S_RD, S_SKIP} st_t;

  st_t        st;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txbyte, rd_left, nxt;
  logic [6:0] ptr;
  logic       is_blk, cnt_pend, mack;
  logic [7:0] store [NREGS];
  logic [7:0] view  [NREGS];

  wire scl      = scl_sy[1];
  wire sda      = sda_sy[1];
  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire start_c  = scl & scl_q & sda_q & ~sda;
  wire stop_c   = scl & scl_q & ~sda_q & sda;
  wire in_rng   = 32'(ptr) < NREGS;
  wire [IW-1:0] pi = ptr[IW-1:0];
  wire [7:0] cnt_val = view[CNT_IDX];

  always_comb begin
    for (int i = 0; i < NREGS; i++) view[i] = store[i];
    view[FS_IDX][FS_W-1:0] = strap_fs;
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_out
    assign regs_out[8*g +: 8] = view[g];
  end

  always_comb begin
    nxt = 8'hFF;
    if (cnt_pend) nxt = cnt_val;
    else if ((!is_blk || rd_left != 8'd0) && in_rng) nxt = view[pi];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in}; sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_sy[1];           sda_q  <= sda_sy[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; shreg <= '0; txbyte <= '0; rd_left <= '0;
      ptr <= '0; is_blk <= 1'b0; cnt_pend <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
      for (int i = 0; i < NREGS; i++) store[i] <= DEFAULTS[8*i +: 8];
    end else if (start_c) begin
      st <= S_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else if (st != S_IDLE && st != S_SKIP) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda};
          bitcnt <= bitcnt + 4'd1;
        end else if (bitcnt == 4'd8) begin
          mack   <= ~sda;
          bitcnt <= 4'd9;
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd9) begin
          sda_oe <= 1'b0;
          bitcnt <= '0;
          if (st == S_RD) begin
            if (mack) begin
              txbyte <= nxt;
              sda_oe <= ~nxt[7];
              if (cnt_pend) begin
                cnt_pend <= 1'b0;
                rd_left  <= cnt_val;
              end else begin
                if (ptr != 7'h7F) ptr <= ptr + 7'd1;
                if (is_blk && rd_left != 8'd0) rd_left <= rd_left - 8'd1;
              end
            end else begin
              st <= S_SKIP;
            end
          end
        end else if (bitcnt == 4'd8) begin
          case (st)
            S_ADDR: begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe   <= 1'b1;
                st       <= shreg[0] ? S_RD : S_CMD;
                cnt_pend <= is_blk;
              end else begin
                st <= S_SKIP;
              end
            end
            S_CMD: begin
              sda_oe <= 1'b1;
              is_blk <= ~shreg[7];
              ptr    <= shreg[7] ? shreg[6:0] : 7'd0;
              st     <= shreg[7] ? S_WR : S_CNT;
            end
            S_CNT: begin
              sda_oe <= 1'b1;
              st     <= S_WR;
            end
            S_WR: begin
              sda_oe <= 1'b1;
              if (in_rng)
                store[pi] <= (shreg & ~RO_MASK[8*pi +: 8]) | (store[pi] & RO_MASK[8*pi +: 8]);
              if (ptr != 7'h7F) ptr <= ptr + 7'd1;
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (st == S_RD && bitcnt != 4'd0) begin
          sda_oe <= ~txbyte[3'd7 - bitcnt[2:0]];
        end
      end
    end
  end
endmodule

// File: rtl/smb_regfile_slave_chk.sv
module smb_regfile_slave_chk #(
  parameter int NREGS = 16,
  parameter int FS_IDX = 0,
  parameter int FS_W = 3,
  parameter logic [8*NREGS-1:0] DEFAULTS = '0,
  parameter logic [8*NREGS-1:0] RO_MASK  = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_in,
  input logic               sda_oe,
  input logic [8*NREGS-1:0] regs_out
);
  localparam logic [8*NREGS-1:0] KEEP =
    ~({{(8*NREGS-FS_W){1'b0}}, {FS_W{1'b1}}} << (8*FS_IDX));

  a_r11_drive_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_in);

  a_r9_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ((regs_out & KEEP) == (DEFAULTS & KEEP)));

  a_r3_write_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_out & KEEP) |-> !scl_in);

  a_r8_ro_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_out & RO_MASK & KEEP) == (DEFAULTS & RO_MASK & KEEP));
endmodule

bind smb_regfile_slave smb_regfile_slave_chk #(
  .NREGS(NREGS), .FS_IDX(FS_IDX), .FS_W(FS_W), .DEFAULTS(DEFAULTS), .RO_MASK(RO_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe), .regs_out(regs_out)
);

// File: tb/test_smb_regfile_slave.sv
module test_smb_regfile_slave;
  localparam int NREGS = 16;
  localparam int HP = 8;
  localparam logic [8*NREGS-1:0] DEF = 128'h00A8A0B4B700E10F2A551000C0BEF800;
  localparam logic [8*NREGS-1:0] ROM = 128'h0000000000000000FF00000000000007;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_oe = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  logic [8*NREGS-1:0] regs_out;
  wire  sda_line = ~(m_oe | sda_oe);

  int compared = 0;
  int mismatched = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  logic [7:0] mdl [NREGS];

  always #5 clk = ~clk;

  smb_regfile_slave #(.NREGS(NREGS), .DEFAULTS(DEF), .RO_MASK(ROM)) i_smb_regfile_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .strap_fs(strap), .regs_out(regs_out)
  );

  function automatic logic [7:0] mview(int off);
    logic [7:0] v;
    if (off >= NREGS) return 8'hFF;
    v = mdl[off];
    if (off == 0) v[2:0] = strap;
    return v;
  endfunction

  function automatic logic [8*NREGS-1:0] mflat();
    logic [8*NREGS-1:0] f;
    for (int i = 0; i < NREGS; i++) f[8*i +: 8] = mview(i);
    return f;
  endfunction

  task automatic chk(logic ok, string tag, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      compared++;
      if (regs_out !== mflat()) begin
        mismatched++;
        $display("FAIL R3/R4/R8 regs_out actual=%0h expected=%0h", regs_out, mflat());
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bstart();
    scl = 1'b0; m_oe = 1'b0; tick(HP);
    scl = 1'b1; tick(HP);
    m_oe = 1'b1; tick(HP);
    scl = 1'b0; tick(HP/2);
  endtask

  task automatic bstop();
    scl = 1'b0; m_oe = 1'b1; tick(HP);
    scl = 1'b1; tick(HP);
    m_oe = 1'b0; tick(HP);
  endtask

  task automatic send(logic [7:0] b, logic exp_ack, string tag, int wr_off);
    logic ack;
    for (int i = 7; i >= 0; i--) begin
      m_oe = ~b[i]; tick(HP);
      scl = 1'b1; tick(HP);
      if (i == 0) cmp_en = 1'b0;
      scl = 1'b0;
    end
    m_oe = 1'b0; tick(HP);
    scl = 1'b1; tick(HP/2);
    ack = ~sda_line;
    chk(ack == exp_ack, tag, ack, exp_ack);
    if (ack && wr_off >= 0 && wr_off < NREGS)
      mdl[wr_off] = (b & ~ROM[8*wr_off +: 8]) | (mdl[wr_off] & ROM[8*wr_off +: 8]);
    cmp_en = 1'b1;
    tick(HP/2);
    scl = 1'b0;
  endtask

  task automatic recv(logic [7:0] exp, logic last, string tag);
    logic [7:0] got;
    m_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(HP);
      scl = 1'b1; tick(HP/2);
      got[i] = sda_line;
      tick(HP/2);
      scl = 1'b0;
    end
    chk(got == exp, tag, got, exp);
    m_oe = ~last; tick(HP);
    scl = 1'b1; tick(HP);
    scl = 1'b0; tick(1);
    m_oe = 1'b0;
  endtask

  task automatic wr_byte(int off, logic [7:0] v, string tag);
    bstart();
    send(8'hD2, 1'b1, "R1", -1);
    send(8'h80 | 8'(off), 1'b1, "R2", -1);
    send(v, 1'b1, tag, off);
    bstop();
  endtask

  task automatic rd_byte(int off, string tag);
    bstart();
    send(8'hD2, 1'b1, "R1", -1);
    send(8'h80 | 8'(off), 1'b1, "R2", -1);
    bstart();
    send(8'hD3, 1'b1, "R1", -1);
    recv(mview(off), 1'b1, tag);
    bstop();
    chk(sda_oe == 1'b0, "R5 released", sda_oe, 0);
  endtask

  task automatic blk_rd(int extra);
    int n;
    n = mview(8);
    bstart();
    send(8'hD2, 1'b1, "R1", -1);
    send(8'h00, 1'b1, "R2", -1);
    bstart();
    send(8'hD3, 1'b1, "R1", -1);
    recv(8'(n), 1'b0, "R6 count");
    for (int i = 0; i < n; i++) recv(mview(i), (extra == 0 && i == n-1), "R6 data");
    for (int i = 0; i < extra; i++) recv(8'hFF, (i == extra-1), "R6 beyond");
    bstop();
  endtask

  initial begin
    for (int i = 0; i < NREGS; i++) mdl[i] = DEF[8*i +: 8];
    tick(5);
    rst_n = 1'b1;
    tick(2);
    chk(regs_out == mflat(), "R9 reset", 0, 0);
    chk(regs_out[71:64] == 8'h0F, "R7 count default", regs_out[71:64], 8'h0F);
    chk(sda_oe == 1'b0, "R9 idle", sda_oe, 0);
    cmp_en = 1'b1;

    wr_byte(1, 8'h3C, "R3");
    rd_byte(1, "R5");
    wr_byte(5, 8'hC3, "R3");
    rd_byte(5, "R5 R2");

    bstart();
    send(8'hA0, 1'b0, "R1 foreign", -1);
    send(8'h81, 1'b0, "R1 foreign", -1);
    send(8'h55, 1'b0, "R1 foreign", -1);
    bstop();
    chk(regs_out == mflat(), "R1 unchanged", 0, 0);

    wr_byte(7, 8'h00, "R8");
    rd_byte(7, "R8 id");
    wr_byte(0, 8'hFF, "R8");
    strap = 3'b010; tick(2);
    rd_byte(0, "R8 strap");

    bstart();
    send(8'hD2, 1'b1, "R1", -1);
    send(8'h00, 1'b1, "R2", -1);
    send(8'h03, 1'b1, "R4 count", -1);
    send(8'hA1, 1'b1, "R4", 0);
    send(8'hA2, 1'b1, "R4", 1);
    send(8'hA3, 1'b1, "R4", 2);
    bstop();
    rd_byte(2, "R4");

    bstart();
    send(8'hD2, 1'b1, "R1", -1);
    send(8'h00, 1'b1, "R2", -1);
    send(8'h05, 1'b1, "R4 count", -1);
    send(8'h11, 1'b1, "R4", 0);
    send(8'h22, 1'b1, "R4", 1);
    bstop();
    rd_byte(2, "R4 partial");

    blk_rd(1);
    wr_byte(8, 8'h03, "R7");
    blk_rd(2);

    rd_byte(32, "R10");
    wr_byte(32, 8'h77, "R10");
    chk(regs_out == mflat(), "R10 no write", 0, 0);

    tick(20);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule